// File: doc/BRIEF.md
# Power-Good Status Aggregator

This block reduces the health of several regulator channels and a set of device-wide fault flags to a single registered, active-high power-good output. Each channel is judged OK or not OK from its enable, its monitor-select bit, its start-up-delay flag, its undervoltage and overvoltage comparator flags, a voltage-change request and a latched short-circuit interrupt. Device-wide, the output is forced low before the device is ready, while the supply is in undervoltage lockout, and while a thermal-shutdown, input-overvoltage or reset interrupt is pending.

A mode input picks between two policies. In gated mode the power-up phase and any voltage ramp are masked: they count as OK until a fixed timeout expires. In continuous mode the same phases count as not OK until the output has settled. Timeouts and debounce run on a 1 µs tick divided down from the system clock. The timeout, the debounce length and the divider ratio are module parameters.

Top module: `pg_aggregator`

## Requirements
- R1: `pg_out` is 0 during reset and while `dev_ready` is 0 or `supply_uvlo` is 1, in both modes.
- R2: A channel with `ch_mon` = 0, or with `ch_mon` = 1 and `ch_en` = 0, counts as OK, unless R8 applies.
- R3: Gated mode (`mode_cont` = 0): a channel in its settle phase counts as OK until TMO_US ticks have passed since the phase began. It is not OK after that until it reaches regulation.
- R4: Continuous mode (`mode_cont` = 1): a channel counts as not OK for its whole settle phase. The settle phase starts on the first clock after it becomes enabled and monitored.
- R5: A settling channel enters regulation, and counts as OK, after DEB_US consecutive ticks with `ch_dly` = 0 and both `ch_uv` and `ch_ov` = 0. Any cycle that breaks the condition restarts the count.
- R6: In regulation, DEB_US consecutive ticks with `ch_uv` or `ch_ov` = 1 make the channel not OK. Shorter excursions have no effect. A faulted channel returns to OK after DEB_US consecutive in-window ticks.
- R7: A `ch_vchg` = 1 request while a channel is in regulation restarts the settle phase with a fresh timeout, under the rules of R3 and R4.
- R8: `ch_sc` = 1 on a channel with `ch_mon` = 1 makes that channel not OK in both modes, whatever its enable.
- R9: Any of `tsd_int`, `ovp_int` or `rst_int` = 1 forces `pg_out` to 0.
- R10: `pg_out` is 1 only when none of R1, R9 or any channel's not-OK condition holds. It changes one clock after its inputs. The tick fires once every CLK_PER_US cycles, first at the CLK_PER_US-th cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cont | input | 1 | 0 = gated policy, 1 = continuous policy |
| dev_ready | input | 1 | Device has reached standby or later |
| supply_uvlo | input | 1 | Supply below undervoltage lockout |
| tsd_int | input | 1 | Pending thermal-shutdown interrupt |
| ovp_int | input | 1 | Pending input-overvoltage interrupt |
| rst_int | input | 1 | Pending reset interrupt flag |
| ch_en | input | N_CH | Channel enable |
| ch_mon | input | N_CH | Channel selected for power-good monitoring |
| ch_dly | input | N_CH | Channel start-up delay running |
| ch_uv | input | N_CH | Channel undervoltage comparator |
| ch_ov | input | N_CH | Channel overvoltage comparator |
| ch_vchg | input | N_CH | Channel voltage-setting change request |
| ch_sc | input | N_CH | Pending channel short-circuit interrupt |
| pg_out | output | 1 | Registered power-good, active high |

## Verification
Within one tick, a channel's debounce count can finish in the same cycle as its settle timeout, or in the same cycle as a new voltage-change request. The first case decides between a brief not-OK pulse in gated mode and none. The second decides whether regulation or a new ramp wins. The bench uses short parameter values so that both counters wrap often. Random window toggling and sparse change requests then line these events up on shared ticks, and directed runs hold the window open for exactly the debounce length. Each cycle the output is compared with a cycle-accurate model built from the requirements, so the outcome of each collision is judged.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_REG    = 2'd2,
        ST_FAULT  = 2'd3
    } chan_st_e;

    typedef struct packed {
        logic en;
        logic mon;
        logic dly;
        logic uv;
        logic ov;
        logic vchg;
        logic sc;
    } chan_in_t;

    typedef struct packed {
        logic ready;
        logic uvlo;
        logic tsd;
        logic ovp;
        logic rstf;
    } glob_in_t;

    function automatic logic in_window(input chan_in_t c);
        return !c.uv && !c.ov;
    endfunction

    function automatic logic is_active(input chan_in_t c);
        return c.en && c.mon;
    endfunction

    function automatic logic glob_blocks(input glob_in_t g);
        return !g.ready || g.uvlo || g.tsd || g.ovp || g.rstf;
    endfunction

endpackage

// File: rtl/pg_tick_gen.sv
module pg_tick_gen #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    generate
        if (CLK_PER_US > 1) begin : g_tick_chk
            AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R10
        end
    endgenerate

endmodule

// File: rtl/pg_chan_eval.sv
module pg_chan_eval
    import pg_pkg::*;
#(
    parameter int TMO_US = 800,
    parameter int DEB_US = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     mode_cont,
    input  chan_in_t cin,
    output logic     chan_ok
);
    localparam int TW = $clog2(TMO_US + 1);
    localparam int DW = $clog2(DEB_US + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_US - 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_US - 1);

    chan_st_e      st_q, st_n;
    logic [TW-1:0] tmr_q, tmr_n;
    logic [DW-1:0] deb_q, deb_n;
    logic          to_q, to_n;
    logic          active, win;

    assign active = is_active(cin);
    assign win    = in_window(cin);

    always_comb begin
        st_n  = st_q;
        tmr_n = tmr_q;
        deb_n = deb_q;
        to_n  = to_q;
        if (!active) begin
            st_n  = ST_OFF;
            tmr_n = '0;
            deb_n = '0;
            to_n  = 1'b0;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    st_n  = ST_SETTLE;
                    tmr_n = '0;
                    deb_n = '0;
                    to_n  = 1'b0;
                end
                ST_SETTLE: begin
                    if (tick && !to_q) begin
                        if (tmr_q == TMO_LAST) to_n = 1'b1;
                        else                   tmr_n = tmr_q + 1'b1;
                    end
                    if (!win || cin.dly) begin
                        deb_n = '0;
                    end else if (tick) begin
                        if (deb_q == DEB_LAST) begin
                            st_n  = ST_REG;
                            deb_n = '0;
                            tmr_n = '0;
                            to_n  = 1'b0;
                        end else begin
                            deb_n = deb_q + 1'b1;
                        end
                    end
                end
                ST_REG: begin
                    if (cin.vchg) begin
                        st_n  = ST_SETTLE;
                        tmr_n = '0;
                        deb_n = '0;
                        to_n  = 1'b0;
                    end else if (win) begin
                        deb_n = '0;
                    end else if (tick) begin
                        if (deb_q == DEB_LAST) begin
                            st_n  = ST_FAULT;
                            deb_n = '0;
                        end else begin
                            deb_n = deb_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (!win) begin
                        deb_n = '0;
                    end else if (tick) begin
                        if (deb_q == DEB_LAST) begin
                            st_n  = ST_REG;
                            deb_n = '0;
                        end else begin
                            deb_n = deb_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_OFF;
            tmr_q <= '0;
            deb_q <= '0;
            to_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            tmr_q <= tmr_n;
            deb_q <= deb_n;
            to_q  <= to_n;
        end
    end

    logic state_ok;
    always_comb begin
        unique case (st_q)
            ST_OFF, ST_REG: state_ok = 1'b1;
            ST_SETTLE:      state_ok = !mode_cont && !to_q;
            default:        state_ok = 1'b0;
        endcase
    end

    assign chan_ok = state_ok && !(cin.mon && cin.sc);

    AST_IDLE_GOES_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> (st_q == ST_OFF)); // R2
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        tmr_q < TW'(TMO_US)); // R3
    AST_DEB_BOUND: assert property (@(posedge clk) disable iff (rst)
        deb_q < DW'(DEB_US)); // R6
    AST_REG_ENTRY_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_REG) ##1 (st_q == ST_REG) |-> $past(win)); // R5

endmodule

// File: rtl/pg_fault_merge.sv
module pg_fault_merge
    import pg_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  glob_in_t        gin,
    input  logic [N_CH-1:0] chan_ok,
    output logic            pg_next
);
    assign pg_next = !glob_blocks(gin) && (&chan_ok);
endmodule

// File: rtl/pg_aggregator.sv
module pg_aggregator
    import pg_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int CLK_PER_US = 125,
    parameter int TMO_US     = 800,
    parameter int DEB_US     = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_cont,
    input  logic            dev_ready,
    input  logic            supply_uvlo,
    input  logic            tsd_int,
    input  logic            ovp_int,
    input  logic            rst_int,
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] ch_mon,
    input  logic [N_CH-1:0] ch_dly,
    input  logic [N_CH-1:0] ch_uv,
    input  logic [N_CH-1:0] ch_ov,
    input  logic [N_CH-1:0] ch_vchg,
    input  logic [N_CH-1:0] ch_sc,
    output logic            pg_out
);
    logic            tick;
    logic [N_CH-1:0] chan_ok;
    logic            pg_next;
    logic            pg_q;
    glob_in_t        gin;

    pg_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_chan
            chan_in_t cin;
            assign cin = '{en: ch_en[i], mon: ch_mon[i], dly: ch_dly[i],
                           uv: ch_uv[i], ov: ch_ov[i], vchg: ch_vchg[i],
                           sc: ch_sc[i]};
            pg_chan_eval #(.TMO_US(TMO_US), .DEB_US(DEB_US)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .tick      (tick),
                .mode_cont (mode_cont),
                .cin       (cin),
                .chan_ok   (chan_ok[i])
            );
        end
    endgenerate

    assign gin = '{ready: dev_ready, uvlo: supply_uvlo, tsd: tsd_int,
                   ovp: ovp_int, rstf: rst_int};

    pg_fault_merge #(.N_CH(N_CH)) u_merge (
        .gin     (gin),
        .chan_ok (chan_ok),
        .pg_next (pg_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pg_q <= 1'b0;
        else     pg_q <= pg_next;
    end

    assign pg_out = pg_q;

    AST_NOT_READY_LOW: assert property (@(posedge clk) disable iff (rst)
        (!dev_ready || supply_uvlo) |=> !pg_out); // R1
    AST_GLOBAL_INT_LOW: assert property (@(posedge clk) disable iff (rst)
        (tsd_int || ovp_int || rst_int) |=> !pg_out); // R9
    AST_SHORT_LOW: assert property (@(posedge clk) disable iff (rst)
        (|(ch_mon & ch_sc)) |=> !pg_out); // R8

endmodule

// File: tb/pg_aggregator_bench.sv
module pg_aggregator_bench;
    localparam int N   = 4;
    localparam int CPU = 4;
    localparam int TMO = 20;
    localparam int DEB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_cont = 1'b0, dev_ready = 1'b0, supply_uvlo = 1'b0;
    logic tsd_int = 1'b0, ovp_int = 1'b0, rst_int = 1'b0;
    logic [N-1:0] ch_en = '0, ch_mon = '0, ch_dly = '0, ch_uv = '0;
    logic [N-1:0] ch_ov = '0, ch_vchg = '0, ch_sc = '0;
    logic pg_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pg_aggregator #(.N_CH(N), .CLK_PER_US(CPU), .TMO_US(TMO), .DEB_US(DEB)) u_pg_aggregator (
        .clk(clk), .rst(rst), .mode_cont(mode_cont), .dev_ready(dev_ready),
        .supply_uvlo(supply_uvlo), .tsd_int(tsd_int), .ovp_int(ovp_int),
        .rst_int(rst_int), .ch_en(ch_en), .ch_mon(ch_mon), .ch_dly(ch_dly),
        .ch_uv(ch_uv), .ch_ov(ch_ov), .ch_vchg(ch_vchg), .ch_sc(ch_sc),
        .pg_out(pg_out)
    );

    // Reference model built from R1..R10: states 0 off, 1 settle, 2 regulation, 3 fault
    int  m_div;
    int  m_st [N];
    int  m_tmr[N];
    int  m_deb[N];
    bit  m_to [N];
    bit  exp_pg;

    function automatic bit chan_ok_f(int st, bit to, bit cont, bit mon, bit sc);
        bit ok;
        case (st)
            1:       ok = !cont && !to;
            3:       ok = 0;
            default: ok = 1;
        endcase
        return ok && !(mon && sc);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0;
            exp_pg = 0;
            for (int i = 0; i < N; i++) begin
                m_st[i] = 0; m_tmr[i] = 0; m_deb[i] = 0; m_to[i] = 0;
            end
        end else begin
            bit tk;
            bit all_ok;
            tk = (m_div == CPU - 1);
            all_ok = 1;
            for (int i = 0; i < N; i++)
                all_ok &= chan_ok_f(m_st[i], m_to[i], mode_cont, ch_mon[i], ch_sc[i]);
            exp_pg = dev_ready && !supply_uvlo && !tsd_int && !ovp_int && !rst_int && all_ok;
            for (int i = 0; i < N; i++) begin
                bit w;
                w = !ch_uv[i] && !ch_ov[i];
                if (!(ch_en[i] && ch_mon[i])) begin
                    m_st[i] = 0; m_tmr[i] = 0; m_deb[i] = 0; m_to[i] = 0;
                end else if (m_st[i] == 0) begin
                    m_st[i] = 1; m_tmr[i] = 0; m_deb[i] = 0; m_to[i] = 0;
                end else if (m_st[i] == 1) begin
                    if (tk && !m_to[i]) begin
                        if (m_tmr[i] == TMO - 1) m_to[i] = 1; else m_tmr[i]++;
                    end
                    if (!w || ch_dly[i]) m_deb[i] = 0;
                    else if (tk) begin
                        if (m_deb[i] == DEB - 1) begin
                            m_st[i] = 2; m_deb[i] = 0; m_tmr[i] = 0; m_to[i] = 0;
                        end else m_deb[i]++;
                    end
                end else if (m_st[i] == 2) begin
                    if (ch_vchg[i]) begin
                        m_st[i] = 1; m_tmr[i] = 0; m_deb[i] = 0; m_to[i] = 0;
                    end else if (w) m_deb[i] = 0;
                    else if (tk) begin
                        if (m_deb[i] == DEB - 1) begin m_st[i] = 3; m_deb[i] = 0; end
                        else m_deb[i]++;
                    end
                end else begin
                    if (!w) m_deb[i] = 0;
                    else if (tk) begin
                        if (m_deb[i] == DEB - 1) begin m_st[i] = 2; m_deb[i] = 0; end
                        else m_deb[i]++;
                    end
                end
            end
            m_div = tk ? 0 : m_div + 1;
        end
    end

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pg_out actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!rst) check(pg_out, exp_pg, cur_req);
        end
    endtask

    bit done = 0;
    initial begin
        #1600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(pg_out, 1'b0, "R1 reset");
        rst = 1'b0;
        cur_req = "R1";
        step(6);
        check(pg_out, 1'b0, "R1 not ready");
        dev_ready = 1'b1; supply_uvlo = 1'b1;
        step(4);
        check(pg_out, 1'b0, "R1 uvlo");
        supply_uvlo = 1'b0;
        cur_req = "R2";
        ch_en = '1; ch_mon = '0; ch_uv = '1;
        step(4);
        check(pg_out, 1'b1, "R2 unmonitored");
        // gated settle with window never reached: OK then timeout
        cur_req = "R3";
        mode_cont = 1'b0; ch_en = 4'b0001; ch_mon = 4'b0001;
        step(10);
        check(pg_out, 1'b1, "R3 gated masking");
        step(TMO * CPU);
        check(pg_out, 1'b0, "R3 gated timeout");
        // window reached: exact debounce
        cur_req = "R5";
        ch_uv = '0;
        step(DEB * CPU + 2);
        check(pg_out, 1'b1, "R5 regulation");
        // short glitch ignored, long excursion faults
        cur_req = "R6";
        ch_ov[0] = 1'b1; step(CPU); ch_ov[0] = 1'b0;
        step(2);
        check(pg_out, 1'b1, "R6 glitch ignored");
        ch_ov[0] = 1'b1; step(DEB * CPU + 2);
        check(pg_out, 1'b0, "R6 excursion");
        ch_ov[0] = 1'b0; step(DEB * CPU + 2);
        check(pg_out, 1'b1, "R6 recovery");
        // voltage change in continuous mode
        cur_req = "R7";
        mode_cont = 1'b1; ch_vchg[0] = 1'b1; ch_uv[0] = 1'b1;
        step(1); ch_vchg[0] = 1'b0;
        step(2);
        check(pg_out, 1'b0, "R7 continuous ramp");
        cur_req = "R4";
        ch_en[1] = 1'b1; ch_mon[1] = 1'b1; ch_uv[0] = 1'b0; ch_dly[1] = 1'b1;
        step(DEB * CPU + 4);
        check(pg_out, 1'b0, "R4 delay running");
        ch_dly[1] = 1'b0;
        step(DEB * CPU + 3);
        check(pg_out, 1'b1, "R4 settled");
        cur_req = "R8";
        ch_sc[2] = 1'b1; ch_mon[2] = 1'b1; ch_en[2] = 1'b0;
        step(2);
        check(pg_out, 1'b0, "R8 short on disabled monitored");
        ch_sc[2] = 1'b0; ch_mon[2] = 1'b0;
        step(2);
        cur_req = "R9";
        rst_int = 1'b1; step(2);
        check(pg_out, 1'b0, "R9 reset flag");
        rst_int = 1'b0; tsd_int = 1'b1; step(2);
        check(pg_out, 1'b0, "R9 thermal");
        tsd_int = 1'b0; ovp_int = 1'b1; step(2);
        check(pg_out, 1'b0, "R9 overvoltage");
        ovp_int = 1'b0; step(2);
        // random phase, compared each cycle (R10 timing via model)
        cur_req = "R10";
        for (int seg = 0; seg < 40; seg++) begin
            mode_cont = seg[0];
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                check(pg_out, exp_pg, cur_req);
                for (int i = 0; i < N; i++) begin
                    if ($urandom_range(39) == 0)  ch_en[i]  = ~ch_en[i];
                    if ($urandom_range(199) == 0) ch_mon[i] = ~ch_mon[i];
                    if ($urandom_range(29) == 0)  ch_dly[i] = ~ch_dly[i];
                    if ($urandom_range(9) == 0)   ch_uv[i]  = ~ch_uv[i];
                    if ($urandom_range(24) == 0)  ch_ov[i]  = ~ch_ov[i];
                    ch_vchg[i] = ($urandom_range(59) == 0);
                    if (ch_sc[i]) ch_sc[i] = ($urandom_range(19) != 0);
                    else          ch_sc[i] = ($urandom_range(299) == 0);
                end
                tsd_int     = ($urandom_range(499) == 0);
                ovp_int     = ($urandom_range(499) == 0);
                rst_int     = ($urandom_range(499) == 0);
                supply_uvlo = ($urandom_range(399) == 0);
                dev_ready   = ($urandom_range(299) != 0);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule